// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block lets a host processor and a coprocessor trade 32-bit message words through a pair of one-way queues. The host reaches the block over a simple register bus. It pushes words toward the coprocessor by writing the outbound window. It collects words from the coprocessor by reading the inbound window. The coprocessor sees two plain valid/ready word ports, one per direction.

Every word carries a channel number in bits [3:0] and a 28-bit payload in bits [31:4]. A payload is normally a 16-byte-aligned message address. The block never alters a word, so the channel nibble reaches the other side unchanged. By convention, host requests travel on channel 8.

Replies may come back in a different order from the requests that caused them. Each side therefore matches words by their content.

Each window has five registers:

| Offset in window | Register | Behaviour |
|---|---|---|
| +0x00 | data | Read in the inbound window: pops a word. Write in the outbound window: pushes a word. |
| +0x10 | poll | Returns the head word without removing it. |
| +0x14 | sender | Returns the identity of whoever pushed the head word. |
| +0x18 | status | Full flag in bit 31, empty flag in bit 30, fill level in the low bits. |
| +0x1C | config | Sticky overflow flag in bit 0. |

The inbound window (coprocessor to host) sits at offset 0x00. The outbound window (host to coprocessor) sits at offset 0x20.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset both queues are empty and `host_rdata` is 0. `cp_out_valid` is 0 and `cp_in_ready` is 1. The status registers at 0x18 and 0x38 read 0x4000_0000.
- R2: A host write to 0x20 pushes `host_wdata` into the outbound queue. Words leave on `cp_out_word` in write order, bit for bit, including the channel nibble in bits [3:0]. While `cp_out_valid` is 1 and `cp_out_ready` is 0, the word on `cp_out_word` holds steady.
- R3: A host write to 0x20 while the outbound queue holds DEPTH (8) words is dropped. It sets bit 0 of the outbound config register (0x3C). That bit stays set until reset. The inbound config register (0x1C) reads 0.
- R4: A word on `cp_in_word` is accepted on a clock edge where `cp_in_valid` and `cp_in_ready` are both 1. `cp_in_ready` is 0 exactly while the inbound queue holds 8 words.
- R5: A host read of 0x00 pops the inbound head. The popped word appears on `host_rdata` after the clock edge that samples `host_rd_en`. Words come out in arrival order.
- R6: A read of 0x10 or 0x30 returns the head word of that window's queue without removing it; the fill level is unchanged. An empty queue reads 0.
- R7: A read of 0x00 while the inbound queue is empty returns the last word popped (0 if none yet) and leaves the queue unchanged.
- R8: A read of 0x14 or 0x34 returns the 2-bit identity of whoever pushed that queue's head word. The value is 0 for the host and 1 for the coprocessor. An empty queue reads 0.
- R9: A read of 0x18 or 0x38 returns a status word. Bit 31 is full, bit 30 is empty and bits [3:0] are the fill level (0 to 8). All other bits are 0.
- R10: Offsets 0x04 to 0x0C and 0x24 to 0x2C read 0. Offset 0x20 also reads 0. An address with bits [1:0] not 00 reads 0. A write to any address other than 0x20 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 6 | Host byte address inside the 64-byte block |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| cp_out_valid | output | 1 | Outbound word available to the coprocessor |
| cp_out_ready | input | 1 | Coprocessor takes the outbound word |
| cp_out_word | output | 32 | Outbound head word |
| cp_in_valid | input | 1 | Coprocessor offers an inbound word |
| cp_in_ready | output | 1 | Inbound queue has room |
| cp_in_word | input | 32 | Inbound word from the coprocessor |

## Verification
The assertions check the following every cycle:
- neither queue is pushed when full or popped when empty;
- the fill level never exceeds the depth;
- the overflow flag never clears once set;
- a stalled outbound word stays stable;
- a poll or an empty data read never removes a word.

Only the bench scenarios can show the following:
- that words arrive bit for bit and in order;
- that the ninth outbound write is really lost;
- that an empty data read repeats the last popped word;
- that the sender codes and status fields read back with the stated encodings.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 32;
  localparam int SRC_W  = 2;
  localparam int ADDR_W = 6;

  typedef enum logic [SRC_W-1:0] {
    SRC_HOST  = 2'd0,
    SRC_COPRO = 2'd1
  } src_e;

  typedef struct packed {
    src_e              src;
    logic [WORD_W-1:0] word;
  } mbx_entry_t;

  // register index = address bits [4:2]; bit 5 picks the window
  localparam logic [2:0] IDX_DATA   = 3'd0;
  localparam logic [2:0] IDX_POLL   = 3'd4;
  localparam logic [2:0] IDX_SENDER = 3'd5;
  localparam logic [2:0] IDX_STATUS = 3'd6;
  localparam logic [2:0] IDX_CONFIG = 3'd7;

  localparam int BIT_FULL  = 31;
  localparam int BIT_EMPTY = 30;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  mbx_entry_t                 push_entry,
  input  logic                       pop,
  output mbx_entry_t                 head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);

  mbx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]  count_q, count_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_entry;
  end

  assign head  = mem[rd_ptr_q];
  assign full  = (count_q == LVL_MAX);
  assign empty = (count_q == '0);
  assign level = count_q;

  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LVL_MAX);
  assert_full_by_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(push));
endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rdata,
  output logic                       out_push,
  output mbx_entry_t                 out_entry,
  input  mbx_entry_t                 out_head,
  input  logic                       out_full,
  input  logic                       out_empty,
  input  logic [$clog2(DEPTH+1)-1:0] out_level,
  output logic                       in_pop,
  input  mbx_entry_t                 in_head,
  input  logic                       in_full,
  input  logic                       in_empty,
  input  logic [$clog2(DEPTH+1)-1:0] in_level
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic              aligned, win_out;
  logic [2:0]        idx;
  logic              wr_data_hit, rd_data_hit;
  mbx_entry_t        sel_head;
  logic              sel_full, sel_empty;
  logic [LVL_W-1:0]  sel_level;
  logic [WORD_W-1:0] status_word;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic [WORD_W-1:0] last_q, last_d;
  logic              ovf_q, ovf_d;

  assign aligned = (addr[1:0] == 2'b00);
  assign win_out = addr[5];
  assign idx     = addr[4:2];

  assign wr_data_hit = wr_en & aligned & win_out & (idx == IDX_DATA);
  assign rd_data_hit = rd_en & aligned & ~win_out & (idx == IDX_DATA);

  assign out_push  = wr_data_hit & ~out_full;
  assign out_entry = '{src: SRC_HOST, word: wdata};
  assign in_pop    = rd_data_hit & ~in_empty;

  assign sel_head  = win_out ? out_head  : in_head;
  assign sel_full  = win_out ? out_full  : in_full;
  assign sel_empty = win_out ? out_empty : in_empty;
  assign sel_level = win_out ? out_level : in_level;

  always_comb begin
    status_word              = '0;
    status_word[BIT_FULL]    = sel_full;
    status_word[BIT_EMPTY]   = sel_empty;
    status_word[LVL_W-1:0]   = sel_level;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      if (!aligned) begin
        rdata_d = '0;
      end else begin
        case (idx)
          IDX_DATA:   rdata_d = win_out ? '0 : (in_empty ? last_q : in_head.word);
          IDX_POLL:   rdata_d = sel_empty ? '0 : sel_head.word;
          IDX_SENDER: rdata_d = sel_empty ? '0 : WORD_W'(sel_head.src);
          IDX_STATUS: rdata_d = status_word;
          IDX_CONFIG: rdata_d = win_out ? WORD_W'(ovf_q) : '0;
          default:    rdata_d = '0;
        endcase
      end
    end
  end

  assign last_d = in_pop ? in_head.word : last_q;
  assign ovf_d  = ovf_q | (wr_data_hit & out_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      last_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      last_q  <= last_d;
      ovf_q   <= ovf_d;
    end
  end

  assign rdata = rdata_q;

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_drop_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_hit && out_full) |=> (out_level == $past(out_level) || out_level == $past(out_level) - 1'b1));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              cp_out_valid,
  input  logic              cp_out_ready,
  output logic [WORD_W-1:0] cp_out_word,
  input  logic              cp_in_valid,
  output logic              cp_in_ready,
  input  logic [WORD_W-1:0] cp_in_word
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             out_push, out_pop, out_full, out_empty;
  mbx_entry_t       out_entry, out_head;
  logic [LVL_W-1:0] out_level;
  logic             in_push, in_pop, in_full, in_empty;
  mbx_entry_t       in_entry, in_head;
  logic [LVL_W-1:0] in_level;

  mbx_fifo #(.DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(out_push), .push_entry(out_entry), .pop(out_pop),
    .head(out_head), .full(out_full), .empty(out_empty), .level(out_level)
  );

  mbx_fifo #(.DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_push), .push_entry(in_entry), .pop(in_pop),
    .head(in_head), .full(in_full), .empty(in_empty), .level(in_level)
  );

  mbx_host_if #(.DEPTH(DEPTH)) u_host_if (
    .clk(clk), .rst_n(rst_n),
    .addr(host_addr), .wr_en(host_wr_en), .rd_en(host_rd_en),
    .wdata(host_wdata), .rdata(host_rdata),
    .out_push(out_push), .out_entry(out_entry), .out_head(out_head),
    .out_full(out_full), .out_empty(out_empty), .out_level(out_level),
    .in_pop(in_pop), .in_head(in_head), .in_full(in_full),
    .in_empty(in_empty), .in_level(in_level)
  );

  // coprocessor side of the outbound queue
  assign cp_out_valid = ~out_empty;
  assign cp_out_word  = out_head.word;
  assign out_pop      = cp_out_valid & cp_out_ready;

  // coprocessor side of the inbound queue
  assign cp_in_ready = ~in_full;
  assign in_push     = cp_in_valid & cp_in_ready;
  assign in_entry    = '{src: SRC_COPRO, word: cp_in_word};

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_out_valid && !cp_out_ready && !host_wr_en) |=> (cp_out_valid && $stable(cp_out_word)));
  assert_in_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_level == LVL_W'(DEPTH)) |-> !cp_in_ready);
  assert_poll_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && host_addr == 6'h10 && !in_push) |=> (in_level == $past(in_level)));
  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && host_addr == 6'h00 && in_empty && !in_push) |=> in_empty);
endmodule

// File: tb/tb_mbx_doorbell.sv
module tb_mbx_doorbell;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic [5:0]  host_addr;
  logic        host_wr_en, host_rd_en;
  logic [31:0] host_wdata, host_rdata;
  logic        cp_out_valid, cp_out_ready;
  logic [31:0] cp_out_word;
  logic        cp_in_valid, cp_in_ready;
  logic [31:0] cp_in_word;

  int checks = 0;
  int errors = 0;
  logic [31:0] out_exp[$];
  logic [31:0] in_exp[$];
  logic [31:0] last_pop;
  logic [31:0] rd;

  mbx_doorbell #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cp_out_valid(cp_out_valid), .cp_out_ready(cp_out_ready), .cp_out_word(cp_out_word),
    .cp_in_valid(cp_in_valid), .cp_in_ready(cp_in_ready), .cp_in_word(cp_in_word)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic host_wr(input logic [5:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [31:0] d);
    host_addr = a; host_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  // driver: outbound word goes to the scoreboard, then to the bus
  task automatic send_out(input logic [31:0] w);
    out_exp.push_back(w);
    host_wr(6'h20, w);
  endtask

  task automatic cp_push(input logic [31:0] w);
    logic acc;
    cp_in_valid = 1'b1; cp_in_word = w;
    acc = cp_in_ready;
    @(negedge clk);
    cp_in_valid = 1'b0;
    if (acc) in_exp.push_back(w);
  endtask

  // monitor: every outbound transfer is compared with the scoreboard
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && cp_out_valid && cp_out_ready) begin
      if (out_exp.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=%h expected=<none>", cp_out_word);
      end else begin
        check("R2 outbound order", cp_out_word, out_exp.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wr_en = 0; host_rd_en = 0; host_wdata = '0;
    cp_out_ready = 0; cp_in_valid = 0; cp_in_word = '0; last_pop = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", host_rdata, 32'h0);
    check("R1 out_valid", {31'b0, cp_out_valid}, 32'h0);
    check("R1 in_ready", {31'b0, cp_in_ready}, 32'h1);
    host_rd(6'h18, rd); check("R1 in status", rd, 32'h4000_0000);
    host_rd(6'h38, rd); check("R1 out status", rd, 32'h4000_0000);

    // R2 streaming outbound words on channel 8
    cp_out_ready = 1'b1;
    send_out({28'h1000_004, 4'h8});
    send_out({28'h1000_008, 4'h8});
    send_out({28'hFFFF_FFF, 4'h3});
    repeat (4) @(negedge clk);
    check("R2 drained", out_exp.size(), 0);

    // R3 R6 R8 R9 fill outbound queue while stalled
    cp_out_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) send_out({24'hA0_0000 + 24'(i), 4'(i), 4'h8});
    check("R2 valid held", {31'b0, cp_out_valid}, 32'h1);
    host_rd(6'h38, rd); check("R9 out full", rd, 32'h8000_0008);
    host_rd(6'h3C, rd); check("R3 no ovf yet", rd, 32'h0);
    host_wr(6'h20, 32'hDEAD_BEE8);  // dropped, not in scoreboard
    host_rd(6'h3C, rd); check("R3 ovf set", rd, 32'h1);
    host_rd(6'h38, rd); check("R3 level kept", rd, 32'h8000_0008);
    host_rd(6'h30, rd); check("R6 out poll", rd, out_exp[0]);
    host_rd(6'h34, rd); check("R8 out sender host", rd, 32'h0);
    host_rd(6'h1C, rd); check("R3 in config", rd, 32'h0);
    cp_out_ready = 1'b1;
    repeat (DEPTH + 3) @(negedge clk);
    cp_out_ready = 1'b0;
    check("R3 dropped word absent", out_exp.size(), 0);
    host_rd(6'h38, rd); check("R9 out empty", rd, 32'h4000_0000);
    host_rd(6'h3C, rd); check("R3 ovf sticky", rd, 32'h1);

    // R4 R5 R6 R7 R8 inbound path
    for (int i = 0; i < DEPTH; i++) cp_push({24'h5B_0000 + 24'(i * 3), 4'(i), 4'(15 - i)});
    check("R4 ready low when full", {31'b0, cp_in_ready}, 32'h0);
    cp_push(32'h7777_7771);  // refused
    check("R4 refused", in_exp.size(), DEPTH);
    host_rd(6'h18, rd); check("R9 in full", rd, 32'h8000_0008);
    host_rd(6'h10, rd); check("R6 in poll", rd, in_exp[0]);
    host_rd(6'h18, rd); check("R6 level after poll", rd, 32'h8000_0008);
    host_rd(6'h14, rd); check("R8 in sender copro", rd, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(6'h00, rd);
      last_pop = in_exp.pop_front();
      check("R5 in pop order", rd, last_pop);
      if (i == 3) begin
        host_rd(6'h18, rd); check("R9 in level 4", rd, 32'h0000_0004);
      end
    end
    check("R4 ready after drain", {31'b0, cp_in_ready}, 32'h1);
    host_rd(6'h00, rd); check("R7 empty read", rd, last_pop);
    host_rd(6'h18, rd); check("R7 still empty", rd, 32'h4000_0000);
    host_rd(6'h14, rd); check("R8 empty sender", rd, 32'h0);
    host_rd(6'h10, rd); check("R6 empty poll", rd, 32'h0);

    // R5 interleaved push and pop
    cp_push(32'h0000_0128);
    cp_push(32'h0000_0238);
    host_rd(6'h00, rd); last_pop = in_exp.pop_front(); check("R5 interleave a", rd, last_pop);
    cp_push(32'h0000_0348);
    host_rd(6'h00, rd); last_pop = in_exp.pop_front(); check("R5 interleave b", rd, last_pop);
    host_rd(6'h00, rd); last_pop = in_exp.pop_front(); check("R5 interleave c", rd, last_pop);
    host_rd(6'h00, rd); check("R7 repeat last", rd, 32'h0000_0348);

    // R10 unmapped, misaligned and ignored writes
    host_rd(6'h04, rd); check("R10 hole in", rd, 32'h0);
    host_rd(6'h24, rd); check("R10 hole out", rd, 32'h0);
    host_rd(6'h20, rd); check("R10 out data read", rd, 32'h0);
    cp_push(32'h0000_0458);
    host_rd(6'h11, rd); check("R10 misaligned", rd, 32'h0);
    host_wr(6'h00, 32'h1234_5678);
    host_wr(6'h38, 32'hFFFF_FFFF);
    host_wr(6'h22, 32'hABCD_0008);
    host_rd(6'h18, rd); check("R10 in untouched", rd, 32'h0000_0001);
    host_rd(6'h38, rd); check("R10 out untouched", rd, 32'h4000_0000);
    host_rd(6'h3C, rd); check("R10 ovf untouched", rd, 32'h1);
    host_rd(6'h00, rd); check("R10 in word intact", rd, 32'h0000_0458);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule